// File: doc/BRIEF.md
# Resampler Phase Oscillator

This block is the phase oscillator that paces a fractional sample-rate converter. It holds a 56-bit phase accumulator. A frequency word is added to the accumulator only in cycles where the filter sequencer raises its advance strobe, which it does when the running filter instruction asks for an oscillator step. When that addition wraps past the top of the 56-bit range, the block raises a one-cycle compute flag. The resampler reads this flag to decide whether to produce an output for the current input. The upper five accumulator bits form an index that picks one of 32 interpolation filter phases. This lets each computed output slide in time against the input grid.

The frequency word is double buffered. A processor first writes a pending word in two parts. The pending word is then copied into the active word that the accumulator uses. The copy happens on a write to an update address, or on an external sync pulse when that path has been enabled. The output rate is the input rate times the active word divided by 2^56. Words from 0x40000000000000 up to 0xFFFFFFFFFFFFFF give rate reductions from 4 down to 1. Smaller words are accepted as written and are not clamped.

Top module: `rsmp_phase_nco`

## Requirements
- R1: Reset clears the accumulator, the active word, the pending word and the sync-enable bit. After reset, `computeOut` is 0 and `phaseIdx` is 0, and advances leave the phase at 0 until a word has been transferred.
- R2: A write to address 0 loads pending bits 31:0 from `cfgWrData[31:0]`. A write to address 1 loads pending bits 55:32 from `cfgWrData[23:0]`, and `cfgWrData[31:24]` is ignored. Pending writes alone do not change the step the accumulator takes.
- R3: A write to address 2 copies the pending word into the active word, and the write data is ignored. The new word is used by advances from the next cycle on.
- R4: A write to address 3 sets the sync-enable bit from `cfgWrData[0]`. When `syncIn` is high in a cycle and sync-enable is 1, the pending word is copied into the active word. When sync-enable is 0, `syncIn` has no effect.
- R5: The accumulator adds the active word only in cycles where `advance` is 1. In all other cycles it holds its value.
- R6: `computeOut` is 1 for exactly the one cycle after an advance whose 56-bit addition carried out. At all other times it is 0.
- R7: `phaseIdx` equals accumulator bits 55:51. It takes its new value one cycle after an advance.
- R8: Any word is accepted without clamping. A word below 0x40000000000000 steps slowly, and 0xFFFFFFFFFFFFFF carries on nearly every advance.
- R9: An advance in the same cycle as a transfer, whether by address 2 or by sync, uses the old active word. A transfer in the same cycle as a pending write copies the old pending value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Processor write enable |
| cfgAddr | input | 2 | Write address: 0 word low, 1 word high, 2 update, 3 control |
| cfgWrData | input | 32 | Write data |
| syncIn | input | 1 | External sync pulse; transfers the word when enabled |
| advance | input | 1 | Sequencer step strobe |
| computeOut | output | 1 | Carry-out flag: compute an output for this input |
| phaseIdx | output | 5 | Interpolation phase index (accumulator top bits) |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions: a transfer together with an advance, a sync pulse together with a pending write, and a sync pulse arriving while the enable is being written. In each of these the old and new words must be told apart only through later phase steps. The stimulus sets up two very different words, a quarter-range word and a nearly full-range word, so that using the wrong one changes the phase index and the carry pattern at once. A long random phase then mixes writes, sync pulses and advances in every combination, checked against a bench model cycle by cycle.

// File: rtl/rnco_pkg.sv
package rnco_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_WORD_LO = 2'd0,
    ADR_WORD_HI = 2'd1,
    ADR_UPDATE  = 2'd2,
    ADR_CTRL    = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic transfer;
    logic step;
  } ncoStrobe_t;
endpackage

// File: rtl/rnco_ctrl.sv
module rnco_ctrl
  import rnco_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              ctrlBit,
  input  logic              syncIn,
  input  logic              advance,
  output ncoStrobe_t        strb,
  output logic              syncEnable
);
  logic wrLo, wrHi, wrUpd, wrCtrl;

  assign wrLo   = cfgWrEn && (cfgAddr == ADR_WORD_LO);
  assign wrHi   = cfgWrEn && (cfgAddr == ADR_WORD_HI);
  assign wrUpd  = cfgWrEn && (cfgAddr == ADR_UPDATE);
  assign wrCtrl = cfgWrEn && (cfgAddr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN)       syncEnable <= 1'b0;
    else if (wrCtrl) syncEnable <= ctrlBit;
  end

  always_comb begin
    strb          = '0;
    strb.loadLo   = wrLo;
    strb.loadHi   = wrHi;
    strb.transfer = wrUpd || (syncIn && syncEnable);
    strb.step     = advance;
  end
endmodule

// File: rtl/rnco_dpath.sv
module rnco_dpath
  import rnco_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int BUS_W = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ncoStrobe_t       strb,
  input  logic [BUS_W-1:0] wrData,
  output logic [ACC_W-1:0] pendWord,
  output logic [ACC_W-1:0] actWord,
  output logic [ACC_W-1:0] accWord,
  output logic             carryQ,
  output logic [IDX_W-1:0] phaseIdx
);
  localparam int HI_W = (ACC_W > BUS_W) ? (ACC_W - BUS_W) : 1;

  logic [ACC_W:0] sumExt;

  generate
    if (ACC_W > BUS_W) begin : g_split
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pendWord <= '0;
        end else begin
          if (strb.loadLo) pendWord[BUS_W-1:0]     <= wrData;
          if (strb.loadHi) pendWord[ACC_W-1:BUS_W] <= wrData[HI_W-1:0];
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN)            pendWord <= '0;
        else if (strb.loadLo) pendWord <= wrData[ACC_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              actWord <= '0;
    else if (strb.transfer) actWord <= pendWord;
  end

  assign sumExt = {1'b0, accWord} + {1'b0, actWord};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accWord <= '0;
      carryQ  <= 1'b0;
    end else begin
      carryQ <= strb.step && sumExt[ACC_W];
      if (strb.step) accWord <= sumExt[ACC_W-1:0];
    end
  end

  assign phaseIdx = accWord[ACC_W-1 -: IDX_W];
endmodule

// File: rtl/rsmp_phase_nco.sv
module rsmp_phase_nco
  import rnco_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int BUS_W = 32,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BUS_W-1:0]  cfgWrData,
  input  logic              syncIn,
  input  logic              advance,
  output logic              computeOut,
  output logic [IDX_W-1:0]  phaseIdx
);
  ncoStrobe_t       strb;
  logic             syncEnable;
  logic [ACC_W-1:0] pendWord, actWord, accWord;

  rnco_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .ctrlBit    (cfgWrData[0]),
    .syncIn     (syncIn),
    .advance    (advance),
    .strb       (strb),
    .syncEnable (syncEnable)
  );

  rnco_dpath #(.ACC_W(ACC_W), .BUS_W(BUS_W), .IDX_W(IDX_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (cfgWrData),
    .pendWord (pendWord),
    .actWord  (actWord),
    .accWord  (accWord),
    .carryQ   (computeOut),
    .phaseIdx (phaseIdx)
  );
endmodule

// File: rtl/rnco_chk.sv
module rnco_chk #(
  parameter int ACC_W = 56,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [1:0]       cfgAddr,
  input logic             syncIn,
  input logic             advance,
  input logic             computeOut,
  input logic [IDX_W-1:0] phaseIdx,
  input logic [ACC_W-1:0] pendWord,
  input logic [ACC_W-1:0] actWord,
  input logic [ACC_W-1:0] accWord,
  input logic             syncEnable
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rstN |=> (accWord == '0 && actWord == '0 && !computeOut && phaseIdx == '0)); // R1
  AST_TRANSFER_COPIES: assert property (@(posedge clk) disable iff (!rstN) (cfgWrEn && cfgAddr == 2'd2) |=> (actWord == $past(pendWord))); // R3
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (!(syncIn && syncEnable) && !(cfgWrEn && cfgAddr == 2'd2)) |=> $stable(actWord)); // R4
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rstN) !advance |=> $stable(accWord)); // R5
  AST_FLAG_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN) !advance |=> !computeOut); // R6
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN) advance |=> (computeOut == (accWord < $past(accWord)))); // R6
endmodule

bind rsmp_phase_nco rnco_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgAddr    (cfgAddr),
  .syncIn     (syncIn),
  .advance    (advance),
  .computeOut (computeOut),
  .phaseIdx   (phaseIdx),
  .pendWord   (pendWord),
  .actWord    (actWord),
  .accWord    (accWord),
  .syncEnable (syncEnable)
);

// File: tb/tb_rsmp_phase_nco.sv
`timescale 1ns/1ps
module tb_rsmp_phase_nco;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgAddr;
  logic [31:0] cfgWrData;
  logic        syncIn;
  logic        advance;
  logic        computeOut;
  logic [4:0]  phaseIdx;

  always #2 clk = ~clk;

  rsmp_phase_nco dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .syncIn(syncIn), .advance(advance),
    .computeOut(computeOut), .phaseIdx(phaseIdx)
  );

  typedef struct {
    logic       co;
    logic [4:0] idx;
    string      tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;
  bit          monOn = 0;

  logic [55:0] mPend, mAct, mAcc;
  logic        mSyncEn;

  // driver: drive one cycle of inputs and push the expected result
  task automatic drive(input bit adv, input bit we, input logic [1:0] addr,
                       input logic [31:0] data, input bit sync, input string tag);
    logic [56:0] s;
    logic        co;
    @(negedge clk);
    advance = adv; cfgWrEn = we; cfgAddr = addr; cfgWrData = data; syncIn = sync;
    s  = {1'b0, mAcc} + {1'b0, mAct};
    co = adv && s[56];
    if (adv) mAcc = s[55:0];
    if ((we && addr == 2'd2) || (sync && mSyncEn)) mAct = mPend;
    if (we && addr == 2'd0) mPend[31:0]  = data;
    if (we && addr == 2'd1) mPend[55:32] = data[23:0];
    if (we && addr == 2'd3) mSyncEn = data[0];
    expQ.push_back('{co, mAcc[55:51], tag});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 2'd0, 32'h0, 0, tag);
  endtask

  task automatic loadWord(input logic [55:0] w, input string tag);
    drive(0, 1, 2'd0, w[31:0], 0, tag);
    drive(0, 1, 2'd1, {8'h00, w[55:32]}, 0, tag);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (monOn && expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (computeOut !== e.co || phaseIdx !== e.idx) begin
          errors++;
          $display("FAIL %s computeOut=%0d exp %0d phaseIdx=%0d exp %0d",
                   e.tag, computeOut, e.co, phaseIdx, e.idx);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgWrEn = 0; cfgAddr = 0; cfgWrData = 0; syncIn = 0; advance = 0;
    mPend = '0; mAct = '0; mAcc = '0; mSyncEn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (computeOut !== 1'b0 || phaseIdx !== 5'd0) begin
      errors++;
      $display("FAIL R1 reset computeOut=%0d exp 0 phaseIdx=%0d exp 0", computeOut, phaseIdx);
    end
    rstN = 1;
    monOn = 1;

    // R1: zero active word keeps phase at 0
    for (int i = 0; i < 3; i++) drive(1, 0, 2'd0, 32'h0, 0, "R1");
    // R2: pending writes alone leave the step unchanged
    loadWord(56'h40000000000000, "R2");
    for (int i = 0; i < 3; i++) drive(1, 0, 2'd0, 32'h0, 0, "R2");
    // R3 + R9: transfer with garbage data, advance in same cycle uses old word
    drive(1, 1, 2'd2, 32'hDEADBEEF, 0, "R9");
    // R6/R7: quarter steps, carry every 4th; R5 gaps hold
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, 2'd0, 32'h0, 0, "R7");
      drive(0, 0, 2'd0, 32'h0, 0, "R5");
    end
    // R4: sync while disabled has no effect
    loadWord(56'hFFFFFFFFFFFFFF, "R2");
    drive(1, 0, 2'd0, 32'h0, 1, "R4");
    for (int i = 0; i < 4; i++) drive(1, 0, 2'd0, 32'h0, 0, "R4");
    // R4: enable written same cycle as sync uses old enable
    drive(0, 1, 2'd3, 32'h1, 1, "R4");
    drive(1, 0, 2'd0, 32'h0, 0, "R4");
    // R4/R9: enabled sync with advance in same cycle
    drive(1, 0, 2'd0, 32'h0, 1, "R9");
    for (int i = 0; i < 6; i++) drive(1, 0, 2'd0, 32'h0, 0, "R8");
    // R2: high-half bits 31:24 ignored; R9: pending write plus sync copies old pending
    drive(0, 1, 2'd0, 32'h0, 0, "R2");
    drive(0, 1, 2'd1, 32'hAB010000, 1, "R9");
    for (int i = 0; i < 4; i++) drive(1, 0, 2'd0, 32'h0, 0, "R9");
    drive(0, 0, 2'd0, 32'h0, 1, "R2");
    // R8: below-range word steps slowly, no clamping
    for (int i = 0; i < 20; i++) drive(1, 0, 2'd0, 32'h0, 0, "R8");
    // R6: mixed random stimulus
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0], r[1] & r[2], r[4:3], $urandom, r[5] & r[6], "R6");
    end
    idle(3, "R5");
    repeat (2) @(posedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule